// File: doc/BRIEF.md
# USB High-Speed Repeater Path Controller

This block is the control state machine of a USB 2.0 high-speed repeater that sits between a host-side port and a device-side (external) port. It chooses how signals travel between them. One route is a re-timing high-speed synchronizer. The other is a transparent bus switch that ties the two ports together electrically. On a device detach it can also float the external port. The analog detectors ahead of it report qualified line events: a high-speed disconnect seen as a doubled amplitude during the end-of-packet of a start-of-frame, J, K and SE0 line states, and completion of the high-speed handshake. The block turns these events, together with an enable pin and a reset, into a state code and three path controls.

A detach in high-speed operation has two possible outcomes, selected by an option bit. The block can drop straight to full/low-speed pass-through. It can instead first spend a fixed isolation period with both paths open and the external port floating, so that the host's own disconnect detector sees the line without cable reflections. After a 3 ms bus idle the block enters suspend. A K state then begins resume, and an SE0 held at the end of resume returns the block to high-speed. Taking the enable pin low ends operation. After reset, the block reaches the disconnected state only once a 10 ms settling delay has passed.

The timers count a reference clock whose ticks per millisecond and per microsecond are parameters. The enable and reset pins are resynchronized through two flops. Path controls are registered and change on the same edge as the state code.

Top module: `usb_rptr_pathctl`

## Requirements
- R1: While the synchronized reset is active, the state code is 0 (settling) and sync_en, bus_sw_en and ext_hiz are all 0. After rst_n rises, the state code stays 0 for exactly 10*MS_TICKS+2 clock edges and then becomes 1 (disconnected).
- R2: In the disconnected state (code 1) only bus_sw_en is 1. The block stays there while the synchronized enable is low and moves to full/low-speed pass-through (code 6) when it is high.
- R3: In full/low-speed pass-through (code 6) only bus_sw_en is 1. A pulse on hs_chirp_done moves the block to high-speed (code 2) on the next edge.
- R4: In high-speed (code 2) only sync_en is 1. An hs_disc pulse with det_en at 0 moves the block to code 6 on the next edge.
- R5: An hs_disc pulse in code 2 with det_en at 1 moves the block to isolation (code 5) on the next edge. In code 5 sync_en and bus_sw_en are 0 and ext_hiz is 1.
- R6: The isolation state lasts exactly 3*MS_TICKS clock edges and then gives way to code 6.
- R7: In code 2, line_j held for 3*MS_TICKS consecutive edges moves the block to suspend (code 3, only bus_sw_en set). Any edge without line_j restarts that count.
- R8: In suspend, a line_k pulse moves the block to resume (code 4, only bus_sw_en set) on the next edge.
- R9: In resume, line_se0 held for 5*US_TICKS consecutive edges returns the block to code 2. Any edge without line_se0 restarts the count.
- R10: A low synchronized enable in any of codes 2 to 6 moves the block to code 1 on the next edge, ahead of every other event. The enable pin has no effect during code 0.
- R11: A change on the enable pin reaches the state code on the third rising edge after it is applied (two synchronizer flops plus the state register).
- R12: sync_en and bus_sw_en are never both 1, and ext_hiz is 1 only in code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for timers and state |
| rst_n | input | 1 | Asynchronous active-low reset request, resynchronized inside |
| enable | input | 1 | Operation enable from the host, resynchronized inside |
| det_en | input | 1 | Static option: 1 routes a detach through the isolation state |
| hs_disc | input | 1 | Qualified high-speed disconnect event (one-clock pulse) |
| hs_chirp_done | input | 1 | Qualified high-speed handshake completion event |
| line_j | input | 1 | Line is in J / idle state |
| line_k | input | 1 | Line is in K state |
| line_se0 | input | 1 | Line is in SE0 state |
| state_code | output | 3 | Current state: 0 settle, 1 disconnected, 2 high-speed, 3 suspend, 4 resume, 5 isolation, 6 full/low-speed |
| sync_en | output | 1 | Enables the high-speed synchronizer path |
| bus_sw_en | output | 1 | Closes the host-to-external bus switch |
| ext_hiz | output | 1 | Floats the external port |

## Verification
The bench measures the exact number of edges for the post-reset settle, the isolation period, the idle-to-suspend count and the end-of-resume SE0 count. A timer that is off by one or that is not cleared on state entry shows up as a cycle-count mismatch. The idle and SE0 counts are broken for one edge partway through. A design that lets the count run on across that gap would enter suspend or high-speed too early. Detach is exercised with both values of det_en, so swapping the two outcomes or leaving the external port driven during isolation is reported. The enable pin is toggled low during settling, where it must be ignored, and in high-speed, where it must win within three edges. This catches a missing or extra synchronizer stage and a wrong priority.

// File: rtl/usb_rptr_pkg.sv
package usb_rptr_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE = 3'd0,
    ST_DISC   = 3'd1,
    ST_HS     = 3'd2,
    ST_SUSP   = 3'd3,
    ST_RESUME = 3'd4,
    ST_ISOL   = 3'd5,
    ST_FSLS   = 3'd6
  } rptr_state_e;

  typedef struct packed {
    logic sync_en;
    logic sw_en;
    logic hiz;
  } path_sel_t;

  function automatic path_sel_t path_of(rptr_state_e s);
    path_sel_t p;
    p = '0;
    case (s)
      ST_HS:                                   p.sync_en = 1'b1;
      ST_DISC, ST_FSLS, ST_SUSP, ST_RESUME:    p.sw_en   = 1'b1;
      ST_ISOL:                                 p.hiz     = 1'b1;
      default:                                 p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/usb_rptr_sync2.sv
module usb_rptr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] pipe;
    always_ff @(posedge clk) begin
      if (clr) pipe <= 2'b00;
      else     pipe <= {pipe[0], d[i]};
    end
    assign q[i] = pipe[1];
  end

  // R11: two-stage latency once the pipe has been out of clear for two edges
  assert_sync_latency_R11: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && !$past(clr, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/usb_rptr_timer.sv
module usb_rptr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          expire
);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (srst || clr) cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
    else             cnt <= '0;
  end

  // R6: the count never reaches the terminal value of the current state
  assert_cnt_below_lim_R6: assert property (@(posedge clk) disable iff (srst)
    cnt < lim);

  // R7: a gap in the qualifying condition restarts the count
  assert_gap_restarts_R7: assert property (@(posedge clk) disable iff (srst)
    (!run) |=> (cnt == '0));

  // R9: an uninterrupted condition advances the count by one
  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (srst)
    (run && !expire && !clr) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/usb_rptr_fsm.sv
module usb_rptr_fsm
  import usb_rptr_pkg::*;
#(
  parameter int MS_TICKS = 125000,
  parameter int US_TICKS = 125,
  parameter int CW       = 21
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          en_s,
  input  logic          det_en,
  input  logic          hs_disc,
  input  logic          hs_chirp_done,
  input  logic          line_j,
  input  logic          line_k,
  input  logic          line_se0,
  input  logic          expire,
  output logic          run,
  output logic [CW-1:0] lim,
  output logic          clr,
  output rptr_state_e   state_q,
  output path_sel_t     path_q
);

  localparam logic [CW-1:0] LIM_SETTLE = CW'(10 * MS_TICKS);
  localparam logic [CW-1:0] LIM_3MS    = CW'(3 * MS_TICKS);
  localparam logic [CW-1:0] LIM_SE0    = CW'(5 * US_TICKS);
  localparam logic [CW-1:0] LIM_NONE   = CW'(1);

  rptr_state_e state_d;
  logic        operating;

  assign operating = (state_q != ST_SETTLE) && (state_q != ST_DISC);

  always_comb begin
    state_d = state_q;
    run     = 1'b0;
    lim     = LIM_NONE;
    case (state_q)
      ST_SETTLE: begin run = 1'b1;     lim = LIM_SETTLE; end
      ST_HS:     begin run = line_j;   lim = LIM_3MS;    end
      ST_RESUME: begin run = line_se0; lim = LIM_SE0;    end
      ST_ISOL:   begin run = 1'b1;     lim = LIM_3MS;    end
      default:   ;
    endcase

    if (operating && !en_s) begin
      state_d = ST_DISC;
    end else begin
      case (state_q)
        ST_SETTLE: if (expire)        state_d = ST_DISC;
        ST_DISC:   if (en_s)          state_d = ST_FSLS;
        ST_FSLS:   if (hs_chirp_done) state_d = ST_HS;
        ST_HS: begin
          if (hs_disc)     state_d = det_en ? ST_ISOL : ST_FSLS;
          else if (expire) state_d = ST_SUSP;
        end
        ST_SUSP:   if (line_k)        state_d = ST_RESUME;
        ST_RESUME: if (expire)        state_d = ST_HS;
        ST_ISOL:   if (expire)        state_d = ST_FSLS;
        default:                      state_d = ST_SETTLE;
      endcase
    end
  end

  assign clr = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (srst) begin
      state_q <= ST_SETTLE;
      path_q  <= '0;
    end else begin
      state_q <= state_d;
      path_q  <= path_of(state_d);
    end
  end

  // R12: the two signal paths are mutually exclusive
  assert_paths_exclusive_R12: assert property (@(posedge clk) disable iff (srst)
    !(path_q.sync_en && path_q.sw_en));

  // R12: floating only during isolation
  assert_hiz_only_isol_R12: assert property (@(posedge clk) disable iff (srst)
    path_q.hiz |-> (state_q == ST_ISOL));

  // R10: enable low wins from every operating state
  assert_enable_low_wins_R10: assert property (@(posedge clk) disable iff (srst)
    (operating && !en_s) |=> (state_q == ST_DISC));

  // R2: disconnected state is held while enable stays low
  assert_disc_hold_R2: assert property (@(posedge clk) disable iff (srst)
    (state_q == ST_DISC && !en_s) |=> (state_q == ST_DISC));

  // R4: direct fall-back when isolation is not selected
  assert_detach_direct_R4: assert property (@(posedge clk) disable iff (srst)
    (state_q == ST_HS && en_s && hs_disc && !det_en) |=> (state_q == ST_FSLS && path_q.sw_en));

  // R5: isolation when selected, external port floating
  assert_detach_isol_R5: assert property (@(posedge clk) disable iff (srst)
    (state_q == ST_HS && en_s && hs_disc && det_en) |=> (state_q == ST_ISOL && path_q.hiz));

  // R8: K in suspend starts resume
  assert_k_resume_R8: assert property (@(posedge clk) disable iff (srst)
    (state_q == ST_SUSP && en_s && line_k) |=> (state_q == ST_RESUME));

endmodule

// File: rtl/usb_rptr_pathctl.sv
module usb_rptr_pathctl
  import usb_rptr_pkg::*;
#(
  parameter int MS_TICKS = 125000,
  parameter int US_TICKS = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       det_en,
  input  logic       hs_disc,
  input  logic       hs_chirp_done,
  input  logic       line_j,
  input  logic       line_k,
  input  logic       line_se0,
  output logic [2:0] state_code,
  output logic       sync_en,
  output logic       bus_sw_en,
  output logic       ext_hiz
);

  localparam int MAX_TC = (10 * MS_TICKS > 5 * US_TICKS) ? 10 * MS_TICKS : 5 * US_TICKS;
  localparam int CW     = $clog2(MAX_TC + 1);

  // Reset request resynchronizer; powers up asserting reset.
  logic [1:0] rst_pipe = 2'b00;
  logic       srst;

  always_ff @(posedge clk) rst_pipe <= {rst_pipe[0], rst_n};
  assign srst = ~rst_pipe[1];

  logic          en_s;
  logic          run, clr, expire;
  logic [CW-1:0] lim;
  rptr_state_e   state_q;
  path_sel_t     path_q;

  usb_rptr_sync2 #(.W(1)) u_en_sync (
    .clk (clk),
    .clr (srst),
    .d   (enable),
    .q   (en_s)
  );

  usb_rptr_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .srst   (srst),
    .clr    (clr),
    .run    (run),
    .lim    (lim),
    .expire (expire)
  );

  usb_rptr_fsm #(
    .MS_TICKS (MS_TICKS),
    .US_TICKS (US_TICKS),
    .CW       (CW)
  ) u_fsm (
    .clk           (clk),
    .srst          (srst),
    .en_s          (en_s),
    .det_en        (det_en),
    .hs_disc       (hs_disc),
    .hs_chirp_done (hs_chirp_done),
    .line_j        (line_j),
    .line_k        (line_k),
    .line_se0      (line_se0),
    .expire        (expire),
    .run           (run),
    .lim           (lim),
    .clr           (clr),
    .state_q       (state_q),
    .path_q        (path_q)
  );

  assign state_code = state_q;
  assign sync_en    = path_q.sync_en;
  assign bus_sw_en  = path_q.sw_en;
  assign ext_hiz    = path_q.hiz;

  // R1: settle state drives nothing
  assert_settle_quiet_R1: assert property (@(posedge clk) disable iff (srst)
    (state_code == 3'd0) |-> !(sync_en || bus_sw_en || ext_hiz));

endmodule

// File: tb/sim_usb_rptr_pathctl.sv
module sim_usb_rptr_pathctl;

  localparam int MS  = 20;
  localparam int US  = 3;
  localparam int T10 = 10 * MS;
  localparam int T3  = 3 * MS;
  localparam int T5  = 5 * US;

  logic clk = 1'b0;
  logic rst_n = 1'b0, enable = 1'b0, det_en = 1'b0, hs_disc = 1'b0;
  logic chirp = 1'b0, lj = 1'b0, lk = 1'b0, lse0 = 1'b0;
  logic [2:0] state_code;
  logic sync_en, bus_sw_en, ext_hiz;

  always #4 clk = ~clk;

  usb_rptr_pathctl #(.MS_TICKS(MS), .US_TICKS(US)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .det_en(det_en),
    .hs_disc(hs_disc), .hs_chirp_done(chirp), .line_j(lj), .line_k(lk),
    .line_se0(lse0), .state_code(state_code), .sync_en(sync_en),
    .bus_sw_en(bus_sw_en), .ext_hiz(ext_hiz)
  );

  int n_chk = 0, n_fail = 0, viol = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int outs();
    return {29'd0, sync_en, bus_sw_en, ext_hiz};
  endfunction

  // Behavioural reference: pipes as bits, timer as an integer.
  int m_state = 0, m_nxt, m_cnt = 0, m_lim;
  bit m_r1 = 0, m_r2 = 0, m_e1 = 0, m_e2 = 0, m_cond, m_fire;

  always @(posedge clk) begin
    m_nxt = m_state; m_cond = 0; m_lim = 1; m_fire = 0;
    if (!m_r2) m_nxt = 0;
    else begin
      case (m_state)
        0: begin m_cond = 1;    m_lim = T10; end
        2: begin m_cond = lj;   m_lim = T3;  end
        4: begin m_cond = lse0; m_lim = T5;  end
        5: begin m_cond = 1;    m_lim = T3;  end
        default: ;
      endcase
      m_fire = m_cond && (m_cnt == m_lim - 1);
      if (m_state >= 2 && !m_e2) m_nxt = 1;
      else case (m_state)
        0: if (m_fire) m_nxt = 1;
        1: if (m_e2) m_nxt = 6;
        6: if (chirp) m_nxt = 2;
        2: if (hs_disc) m_nxt = det_en ? 5 : 6; else if (m_fire) m_nxt = 3;
        3: if (lk) m_nxt = 4;
        4: if (m_fire) m_nxt = 2;
        5: if (m_fire) m_nxt = 6;
        default: m_nxt = 0;
      endcase
    end
    if (!m_r2 || m_nxt != m_state) m_cnt = 0;
    else if (m_cond) m_cnt++;
    else m_cnt = 0;
    if (!m_r2) begin m_e1 = 0; m_e2 = 0; end
    else begin m_e2 = m_e1; m_e1 = enable; end
    m_r2 = m_r1; m_r1 = rst_n;
    m_state = m_nxt;
  end

  function automatic int m_outs(int s);
    case (s)
      2: return 4;
      1, 3, 4, 6: return 2;
      5: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int s);
    case (s)
      0: return "R1"; 1: return "R2"; 2: return "R4"; 3: return "R7";
      4: return "R9"; 5: return "R5"; default: return "R3";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(req_of(m_state), "model state", int'(state_code), m_state);
      chk(req_of(m_state), "model outputs", outs(), m_outs(m_state));
    end
    if (sync_en && bus_sw_en) viol++;
    if (ext_hiz && state_code != 3'd5) viol++;
  end

  task automatic edges_to_change(output int n);
    logic [2:0] s0;
    s0 = state_code;
    n = 0;
    while (state_code == s0 && n < 5000) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  task automatic pulse_step(ref logic sig);
    sig = 1'b1; @(negedge clk); sig = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    chk("R1", "state in reset", int'(state_code), 0);
    chk("R1", "outputs in reset", outs(), 0);

    // R1/R10: settle timing with enable held low (ignored in settle)
    rst_n = 1'b1;
    edges_to_change(n);
    chk("R1", "settle edges", n, T10 + 2);
    chk("R10", "state after settle, enable low", int'(state_code), 1);
    chk("R2", "disconnected outputs", outs(), 2);
    repeat (20) @(negedge clk);
    chk("R2", "held while enable low", int'(state_code), 1);

    // R11: enable latency
    enable = 1'b1;
    edges_to_change(n);
    chk("R11", "enable latency edges", n, 3);
    chk("R2", "enable leads to fs/ls", int'(state_code), 6);
    chk("R3", "fs/ls outputs", outs(), 2);

    pulse_step(chirp);
    chk("R3", "handshake to hs", int'(state_code), 2);
    chk("R4", "hs outputs", outs(), 4);

    det_en = 1'b0;
    pulse_step(hs_disc);
    chk("R4", "direct detach", int'(state_code), 6);
    chk("R4", "outputs after direct detach", outs(), 2);

    pulse_step(chirp);
    det_en = 1'b1;
    pulse_step(hs_disc);
    chk("R5", "isolation entry", int'(state_code), 5);
    chk("R5", "isolation outputs", outs(), 1);
    edges_to_change(n);
    chk("R6", "isolation edges", n, T3);
    chk("R6", "state after isolation", int'(state_code), 6);

    // R7: idle count with a one-edge gap
    pulse_step(chirp);
    lj = 1'b1;
    repeat (T3 - 5) @(negedge clk);
    chk("R7", "still hs before gap", int'(state_code), 2);
    lj = 1'b0;
    @(negedge clk);
    chk("R7", "still hs at gap", int'(state_code), 2);
    lj = 1'b1;
    edges_to_change(n);
    chk("R7", "idle edges after gap", n, T3);
    chk("R7", "suspend state", int'(state_code), 3);
    chk("R7", "suspend outputs", outs(), 2);
    lj = 1'b0;

    pulse_step(lk);
    chk("R8", "resume state", int'(state_code), 4);
    chk("R8", "resume outputs", outs(), 2);

    // R9: SE0 count with a one-edge gap
    lse0 = 1'b1;
    repeat (T5 - 2) @(negedge clk);
    chk("R9", "still resume before gap", int'(state_code), 4);
    lse0 = 1'b0;
    @(negedge clk);
    lse0 = 1'b1;
    edges_to_change(n);
    chk("R9", "se0 edges after gap", n, T5);
    chk("R9", "back to hs", int'(state_code), 2);
    lse0 = 1'b0;

    enable = 1'b0;
    edges_to_change(n);
    chk("R10", "enable low edges from hs", n, 3);
    chk("R10", "state after enable low", int'(state_code), 1);
    chk("R2", "disconnected switch closed", outs(), 2);

    repeat (4) @(negedge clk);
    chk("R12", "exclusivity violations", viol, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule